// File: doc/BRIEF.md
# Cache SRAM data port controller

This block sits between a processor-side cache request port and an external synchronous cache SRAM. A request carries an address, a direction and, for a write, a 64-bit double word. The block turns each accepted request into one SRAM beat. It drives an active-low chip select, an active-low write strobe and the address. It drives the data bus and an eight-bit parity bus through separate output enables, which stand in for tri-state drivers.

Every transfer is a full double word. On a write the block generates odd parity for each byte lane. On a read it samples the returned data and parity a fixed number of cycles after the SRAM has seen the select. It reports the data with a one-cycle valid strobe and an eight-bit vector that flags each byte lane whose parity is wrong. Requests in the same direction issue on consecutive cycles. When the direction changes, the block lowers its ready so that both buses stay undriven for at least one cycle. During reset the select is held inactive.

Top module: `cache_sram_port`

## Requirements
- R1: While `rst` is high, after each clock edge `sram_ce_n` and `sram_we_n` are 1, both output enables are 0, `req_ready` is 0 and `rd_valid` is 0. A request presented during reset is never issued.
- R2: A request accepted at an edge (`req_valid` and `req_ready` both high) puts `sram_ce_n`=0 on the pins for the next cycle, together with its address and `sram_we_n` equal to the inverse of `req_write`. In a cycle that follows an edge with no acceptance, `sram_ce_n` is 1.
- R3: For an accepted write, `sram_dq_oe` and `sram_dp_oe` are both 1 for exactly the following cycle, and `sram_dq_out` carries the full 64-bit `req_wdata`. Neither enable is 1 in any other cycle.
- R4: Write parity is odd per byte. `sram_dp_out[j]` covers `sram_dq_out[8j+7:8j]`, so that byte plus its parity bit holds an odd number of ones. Byte lane 0 is the most significant byte, bits 63:56, and is covered by parity index 7.
- R5: A read accepted at edge T is captured from `sram_dq_in` at edge T+1+RD_LAT (default RD_LAT=2). After that edge, `rd_valid` is 1 for one cycle and `rd_data` holds the captured word.
- R6: With the read result, `rd_perr[j]` is 1 exactly when `sram_dq_in[8j+7:8j]` together with `sram_dp_in[j]` holds an even number of ones. A single flipped data or parity bit sets only the bit of its own lane.
- R7: After a write is accepted at edge W, a read is not ready at edge W+1. This leaves the buses undriven for one cycle before the read.
- R8: After a read is accepted at edge T, a write is not ready before edge T+RD_LAT+2. This leaves one undriven cycle after the SRAM's read data before write data is driven.
- R9: When no direction change is pending, ready stays high. Back-to-back writes, and back-to-back reads, issue on consecutive edges.
- R10: A request that meets a low `req_ready` is stalled, not dropped. It issues once ready rises, and requests complete in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | SRAM word address |
| req_wdata | input | DW | Write double word |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | DW | Captured read data |
| rd_perr | output | DW/8 | Per-lane parity error flags |
| sram_ce_n | output | 1 | SRAM select, active low |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| sram_addr | output | AW | SRAM address |
| sram_dq_out | output | DW | Data driven on writes |
| sram_dq_in | input | DW | Data returned on reads |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dp_out | output | DW/8 | Parity driven on writes |
| sram_dp_in | input | DW/8 | Parity returned on reads |
| sram_dp_oe | output | 1 | Parity bus drive enable |

## Verification
Pin outputs (select, strobe, address, enables, write data and parity) are due in the cycle right after the accepting edge. Read results are due one cycle after edge T+1+RD_LAT, and ready is a same-cycle function of the direction and of the last accepts. The bench keeps a behavioural reference that records the edge index of every accept and queues each read with its due edge. Outputs are compared against that reference at every falling clock edge, so each result is sampled in the cycle it is due and in no other. The SRAM model returns data exactly RD_LAT cycles after it samples the select, and it flags any cycle in which both sides would drive.

// File: rtl/cache_port_pkg.sv
package cache_port_pkg;

  // Odd parity bit for one byte: makes the total count of ones odd.
  function automatic logic lane_odd_par(input logic [7:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/csp_lane_parity.sv
module csp_lane_parity #(
  parameter int NB = 8
) (
  input  logic [8*NB-1:0] data,
  output logic [NB-1:0]   par
);
  import cache_port_pkg::*;

  for (genvar j = 0; j < NB; j++) begin : g_lane
    assign par[j] = lane_odd_par(data[8*j +: 8]);
  end

endmodule

// File: rtl/csp_issue.sv
module csp_issue #(
  parameter int AW     = 10,
  parameter int DW     = 64,
  parameter int NB     = DW / 8,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NB-1:0] req_wpar,
  output logic          req_ready,
  output logic          rd_fire,
  output logic          ce_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dq_out,
  output logic [NB-1:0] dp_out,
  output logic          bus_oe
);
  localparam int CW = $clog2(RD_LAT + 2);
  localparam logic [CW-1:0] RD_HOLD = CW'(RD_LAT + 1);

  logic [CW-1:0] rd_gap;  // edges left before a write may follow a read
  logic          wr_gap;  // one edge of quiet before a read may follow a write
  logic          fire;

  always_comb begin
    if (rst)            req_ready = 1'b0;
    else if (req_write) req_ready = (rd_gap == '0);
    else                req_ready = !wr_gap;
  end

  assign fire    = req_valid && req_ready;
  assign rd_fire = fire && !req_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n   <= 1'b1;
      we_n   <= 1'b1;
      bus_oe <= 1'b0;
      addr   <= '0;
      dq_out <= '0;
      dp_out <= '0;
      rd_gap <= '0;
      wr_gap <= 1'b0;
    end else begin
      ce_n   <= !fire;
      we_n   <= !(fire && req_write);
      bus_oe <= fire && req_write;
      wr_gap <= fire && req_write;
      if (fire) addr <= req_addr;
      if (fire && req_write) begin
        dq_out <= req_wdata;
        dp_out <= req_wpar;
      end
      if (rd_fire)            rd_gap <= RD_HOLD;
      else if (rd_gap != '0)  rd_gap <= rd_gap - CW'(1);
    end
  end

endmodule

// File: rtl/csp_rd_capture.sv
module csp_rd_capture #(
  parameter int DW     = 64,
  parameter int NB     = DW / 8,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_fire,
  input  logic [DW-1:0] dq_in,
  input  logic [NB-1:0] dp_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [NB-1:0] rd_perr
);
  logic [RD_LAT:0] pend;      // pend[k]: a read was accepted k+1 edges ago
  logic [NB-1:0]   want_par;

  csp_lane_parity #(.NB(NB)) u_chk_par (
    .data (dq_in),
    .par  (want_par)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_perr  <= '0;
    end else begin
      pend     <= {pend[RD_LAT-1:0], rd_fire};
      rd_valid <= pend[RD_LAT];
      if (pend[RD_LAT]) begin
        rd_data <= dq_in;
        rd_perr <= want_par ^ dp_in;
      end
    end
  end

endmodule

// File: rtl/cache_sram_port.sv
module cache_sram_port #(
  parameter int AW     = 10,
  parameter int DW     = 64,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [DW/8-1:0]   rd_perr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic [AW-1:0]     sram_addr,
  output logic [DW-1:0]     sram_dq_out,
  input  logic [DW-1:0]     sram_dq_in,
  output logic              sram_dq_oe,
  output logic [DW/8-1:0]   sram_dp_out,
  input  logic [DW/8-1:0]   sram_dp_in,
  output logic              sram_dp_oe
);
  localparam int NB = DW / 8;

  logic [NB-1:0] wpar;
  logic          rd_fire;
  logic          bus_oe;

  csp_lane_parity #(.NB(NB)) u_gen_par (
    .data (req_wdata),
    .par  (wpar)
  );

  csp_issue #(.AW(AW), .DW(DW), .NB(NB), .RD_LAT(RD_LAT)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_wpar  (wpar),
    .req_ready (req_ready),
    .rd_fire   (rd_fire),
    .ce_n      (sram_ce_n),
    .we_n      (sram_we_n),
    .addr      (sram_addr),
    .dq_out    (sram_dq_out),
    .dp_out    (sram_dp_out),
    .bus_oe    (bus_oe)
  );

  assign sram_dq_oe = bus_oe;
  assign sram_dp_oe = bus_oe;

  csp_rd_capture #(.DW(DW), .NB(NB), .RD_LAT(RD_LAT)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .rd_fire  (rd_fire),
    .dq_in    (sram_dq_in),
    .dp_in    (sram_dp_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_perr  (rd_perr)
  );

endmodule

// File: rtl/cache_sram_port_chk.sv
module cache_sram_port_chk #(
  parameter int DW     = 64,
  parameter int RD_LAT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe,
  input logic              sram_dp_oe,
  input logic [DW-1:0]     sram_dq_out,
  input logic [DW/8-1:0]   sram_dp_out
);
  localparam int NB = DW / 8;
  localparam int SW = $clog2(RD_LAT + 3);
  localparam logic [SW-1:0] SAT = SW'(RD_LAT + 2);

  // Cycles since a read was last seen on the SRAM pins (saturating).
  logic [SW-1:0] since_rd;
  always_ff @(posedge clk) begin
    if (rst)                         since_rd <= SAT;
    else if (!sram_ce_n && sram_we_n) since_rd <= '0;
    else if (since_rd != SAT)        since_rd <= since_rd + SW'(1);
  end

  p_reset_safe_r1: assert property (@(posedge clk)
    rst |=> (sram_ce_n && sram_we_n && !sram_dq_oe && !sram_dp_oe));

  p_issue_sel_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !sram_ce_n);

  p_idle_sel_r2: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> sram_ce_n);

  p_oe_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (sram_dq_oe == sram_dp_oe) && (!sram_dq_oe || (!sram_ce_n && !sram_we_n)));

  for (genvar j = 0; j < NB; j++) begin : g_par
    p_odd_lane_r4: assert property (@(posedge clk) disable iff (rst)
      sram_dp_oe |-> ($countones({sram_dq_out[8*j +: 8], sram_dp_out[j]}) % 2 == 1));
  end

  p_wr_then_rd_r7: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && !sram_we_n) |=> !(!sram_ce_n && sram_we_n));

  p_rd_then_wr_r8: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (since_rd >= SW'(RD_LAT + 1)));

  p_wr_stream_r9: assert property (@(posedge clk) disable iff (rst)
    (sram_dq_oe && req_valid && req_write) |-> req_ready);

endmodule

bind cache_sram_port cache_sram_port_chk #(.DW(DW), .RD_LAT(RD_LAT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .sram_ce_n   (sram_ce_n),
  .sram_we_n   (sram_we_n),
  .sram_dq_oe  (sram_dq_oe),
  .sram_dp_oe  (sram_dp_oe),
  .sram_dq_out (sram_dq_out),
  .sram_dp_out (sram_dp_out)
);

// File: tb/sim_cache_sram_port.sv
`timescale 1ns/1ps
module sim_cache_sram_port;
  localparam int AW  = 10;
  localparam int DW  = 64;
  localparam int NB  = DW / 8;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, sram_ce_n, sram_we_n, sram_dq_oe, sram_dp_oe;
  logic [DW-1:0] rd_data, sram_dq_out;
  logic [DW-1:0] sram_dq_in = '0;
  logic [NB-1:0] rd_perr, sram_dp_out;
  logic [NB-1:0] sram_dp_in = '0;
  logic [AW-1:0] sram_addr;

  always #2.5 clk = ~clk;

  cache_sram_port #(.AW(AW), .DW(DW), .RD_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_perr(rd_perr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe),
    .sram_dp_out(sram_dp_out), .sram_dp_in(sram_dp_in), .sram_dp_oe(sram_dp_oe)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] odd_lanes(input logic [DW-1:0] d);
    logic [NB-1:0] p;
    for (int j = 0; j < NB; j++) p[j] = ($countones(d[8*j +: 8]) % 2 == 0);
    return p;
  endfunction

  // kinds: 0 write, 1 read, 2 flip data bit, 3 flip parity bit, 4 idle cycles
  typedef struct { int kind; int addr; logic [DW-1:0] data; int arg; } op_t;
  op_t ops[$];

  task automatic add(input int k, input int a, input logic [DW-1:0] d, input int g);
    op_t o;
    o.kind = k; o.addr = a; o.data = d; o.arg = g;
    ops.push_back(o);
  endtask

  logic [DW-1:0] mem  [0:(1<<AW)-1];
  logic [NB-1:0] pmem [0:(1<<AW)-1];
  logic [NB-1:0] inj  [int];
  int due_q[$];
  int dad_q[$];
  logic          ln_v [LAT];
  logic [DW-1:0] ln_d [LAT];
  logic [NB-1:0] ln_p [LAT];

  logic exp_ce_n = 1'b1, exp_we_n = 1'b1, exp_oe = 1'b0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_wd = '0;

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    int cur, last_rd, last_wr, nxt, a;
    bit er, acc, erv, ov, finished;
    logic [DW-1:0] od;
    logic [NB-1:0] op_, em;
    string tg;
    op_t h;

    for (int i = 0; i < LAT; i++) begin ln_v[i] = 0; ln_d[i] = '0; ln_p[i] = '0; end
    for (int i = 0; i < (1<<AW); i++) begin mem[i] = '0; pmem[i] = '0; end

    add(4, 0, '0, 2);
    add(0, 1, 64'h0, 0);
    add(0, 2, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    add(0, 3, 64'h0123_4567_89AB_CDEF, 0);
    add(0, 4, 64'h8000_0000_0000_0001, 0);
    add(1, 1, '0, 0); add(1, 2, '0, 0); add(1, 3, '0, 0); add(1, 4, '0, 0);
    add(0, 5, 64'hA5A5_5A5A_C3C3_3C3C, 0);
    add(1, 5, '0, 0);
    add(2, 3, '0, 63);   // lane 0 (bits 63:56) -> error bit 7
    add(2, 4, '0, 0);    // lowest byte -> error bit 0
    add(3, 2, '0, 3);    // parity bit 3 -> error bit 3
    add(2, 1, '0, 8);
    add(2, 1, '0, 40);
    add(1, 3, '0, 0); add(1, 4, '0, 0); add(1, 2, '0, 0); add(1, 1, '0, 0);
    add(4, 0, '0, 3);
    add(0, 6, 64'h5A5A_0F0F_F0F0_1234, 0); add(1, 6, '0, 0);
    add(0, 7, 64'hFEDC_BA98_7654_3210, 0); add(1, 7, '0, 0);
    add(0, 3, 64'h1111_2222_4444_8888, 0); add(1, 3, '0, 0);

    last_rd = -100; last_wr = -100; finished = 0;
    req_valid = 1; req_write = 1; req_addr = 9; req_wdata = 64'hDEAD;
    @(negedge clk);
    cur = 1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      // 1: compare outputs with the reference
      tg = rst ? "R1" : "R2";
      chk(sram_ce_n === exp_ce_n, tg, 64'(sram_ce_n), 64'(exp_ce_n));
      chk(sram_we_n === exp_we_n, tg, 64'(sram_we_n), 64'(exp_we_n));
      if (!exp_ce_n) chk(sram_addr === exp_addr, "R2", 64'(sram_addr), 64'(exp_addr));
      chk(sram_dq_oe === exp_oe && sram_dp_oe === exp_oe, "R3",
          64'({sram_dq_oe, sram_dp_oe}), 64'({exp_oe, exp_oe}));
      if (exp_oe) begin
        chk(sram_dq_out === exp_wd, "R3", sram_dq_out, exp_wd);
        chk(sram_dp_out === odd_lanes(exp_wd), "R4", 64'(sram_dp_out), 64'(odd_lanes(exp_wd)));
      end
      erv = (due_q.size() > 0) && (due_q[0] == cur);
      chk(rd_valid === erv, rst ? "R1" : "R5", 64'(rd_valid), 64'(erv));
      if (erv) begin
        void'(due_q.pop_front());
        a = dad_q.pop_front();
        chk(rd_data === mem[a], "R5", rd_data, mem[a]);
        em = inj.exists(a) ? inj[a] : '0;
        chk(rd_perr === em, "R6", 64'(rd_perr), 64'(em));
      end
      if (!rst && ops.size() == 0 && due_q.size() == 0) begin
        finished = 1;
        break;
      end

      // 2: SRAM model
      if (!sram_ce_n && !sram_we_n) begin
        mem[sram_addr]  = sram_dq_out;
        pmem[sram_addr] = sram_dp_out;
      end
      ov = ln_v[LAT-1]; od = ln_d[LAT-1]; op_ = ln_p[LAT-1];
      if (ov || sram_dq_oe)
        chk(!(ov && sram_dq_oe), "R8", 64'(sram_dq_oe), 64'(0));
      for (int k = LAT-1; k > 0; k--) begin
        ln_v[k] = ln_v[k-1]; ln_d[k] = ln_d[k-1]; ln_p[k] = ln_p[k-1];
      end
      ln_v[0] = !sram_ce_n && sram_we_n;
      ln_d[0] = mem[sram_addr];
      ln_p[0] = pmem[sram_addr];
      sram_dq_in = ov ? od : '0;
      sram_dp_in = ov ? op_ : '0;

      // 3: stimulus
      if (cyc == 4) rst = 0;
      if (!rst) begin
        req_valid = 0;
        while (ops.size() > 0 && (ops[0].kind == 2 || ops[0].kind == 3) && due_q.size() == 0) begin
          h = ops.pop_front();
          if (!inj.exists(h.addr)) inj[h.addr] = '0;
          if (h.kind == 2) begin
            mem[h.addr][h.arg] = ~mem[h.addr][h.arg];
            inj[h.addr][h.arg / 8] = ~inj[h.addr][h.arg / 8];
          end else begin
            pmem[h.addr][h.arg] = ~pmem[h.addr][h.arg];
            inj[h.addr][h.arg] = ~inj[h.addr][h.arg];
          end
        end
        if (ops.size() > 0) begin
          h = ops[0];
          if (h.kind == 4) begin
            h.arg--;
            void'(ops.pop_front());
            if (h.arg > 0) ops.push_front(h);
          end else if (h.kind <= 1) begin
            req_valid = 1;
            req_write = (h.kind == 0);
            req_addr  = AW'(h.addr);
            req_wdata = h.data;
          end
        end
      end
      #1;

      // 4: expected ready and acceptance at the next edge
      nxt = cur + 1;
      if (rst) er = 0;
      else if (req_write) er = (nxt - last_rd >= LAT + 2);
      else er = (nxt - last_wr >= 2);
      tg = rst ? "R1" : (er ? "R9" : (req_write ? "R8" : "R7"));
      chk(req_ready === er, tg, 64'(req_ready), 64'(er));
      if (req_valid && !er && !rst) chk(ops.size() > 0, "R10", 64'(ops.size()), 64'(1));
      acc = req_valid && er && !rst;

      // 5: reference update
      exp_ce_n = !acc;
      exp_we_n = !(acc && req_write);
      exp_oe   = acc && req_write;
      if (acc) begin
        exp_addr = req_addr;
        if (req_write) begin
          exp_wd = req_wdata;
          last_wr = nxt;
          if (inj.exists(int'(req_addr))) inj.delete(int'(req_addr));
        end else begin
          last_rd = nxt;
          due_q.push_back(nxt + 1 + LAT);
          dad_q.push_back(int'(req_addr));
        end
        void'(ops.pop_front());
      end

      @(posedge clk);
      @(negedge clk);
      cur++;
    end
    if (!finished) begin
      fails++;
      $display("FAIL R10 run did not drain actual=%0d expected=0", ops.size());
    end
    done = 1;
    summary();
    $finish;
  end

endmodule